// File: doc/BRIEF.md
# Transition Density Loss Detector

This block watches a recovered serial bit stream, one bit per bit-clock cycle, and raises an active-low line-fault flag when the stream stops toggling. A framer upstream supplies a strobe on the last bit of every 10-bit character. The block compares each bit with the one before it. It keeps a saturating count of quiet bits, meaning bits equal to their predecessor. For each character it records whether any transition fell inside it.

The fault sets quickly but clears slowly. Sixty quiet bits in a row take a healthy link into fault. Leaving fault needs three back-to-back characters that each hold at least one transition. Deasserting the enable input models a powered-down receiver, and the flag is then held in fault.

The control is a small state machine with four states:

- `ST_OFF`: the channel is disabled.
- `ST_FAULT`: the line is failed and no release is in progress.
- `ST_QUAL`: release is being qualified, with a count of good characters seen so far.
- `ST_LINK`: the line is healthy.

Its transitions are:

- Disable: from any state to `ST_OFF` whenever enable is low.
- Wake: from `ST_OFF` to `ST_FAULT` on the first enabled cycle.
- First good character: from `ST_FAULT` to `ST_QUAL`.
- Further good characters: `ST_QUAL` stays in `ST_QUAL` and the count advances.
- Release: from `ST_QUAL` to `ST_LINK` on the third good character.
- Bad character: from `ST_QUAL` to `ST_FAULT`.
- Quiet limit: from `ST_QUAL` or `ST_LINK` to `ST_FAULT`.

Top module: `trans_density_mon`

## Requirements
- R1: After a synchronous reset, `link_fault_n` is 0 in the cycle following reset. It becomes 1 only through the release rule of R5.
- R2: A transition is a bit that differs from the bit sampled in the previous enabled cycle. The first bit after reset or after re-enable has no predecessor and is never a transition.
- R3: While `link_fault_n` is 1, a run of 60 consecutive quiet bits drives it to 0 right after the 60th such bit. A run of 59 leaves it at 1.
- R4: Any transition restarts the quiet-bit run from zero.
- R5: A character is the span of bits that ends with a bit where `char_end` is 1. While in fault, three consecutive characters that each contain at least one transition set `link_fault_n` to 1 right after the `char_end` bit of the third.
- R6: During release qualification, a character with no transition discards the progress made so far, and the full count of three good characters must start again.
- R7: A transition on the very bit that carries `char_end` counts toward the character that bit closes.
- R8: When `en` is 0, `link_fault_n` is 0 after that cycle and stays 0. After `en` returns to 1, release again requires R5.
- R9: A transition-free stretch of any length, hundreds of bits included, never releases the fault, because the quiet counter saturates rather than wrapping.
- R10: If `en` falls in the cycle that carries the third qualifying `char_end`, the disable wins and `link_fault_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Receive channel enable, active high |
| rx_bit | input | 1 | Recovered serial data bit |
| char_end | input | 1 | High on the last bit of each 10-bit character |
| link_fault_n | output | 1 | Line fault, active low (0 = link failed) |

## Verification
Two functions can land on the same bit. One is the closing of a character. The other is either the detection of a transition or the disabling of the channel.

The first pairing is provoked by a character whose only transition is on its `char_end` bit. That character must still count as good, so release is judged on whether it completes after exactly three characters.

The second pairing is provoked by dropping `en` on the `char_end` bit of the third qualifying character. The flag must stay low there, and also through the next good character once the channel is enabled again.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    // Control states of the line-fault machine
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,   // channel disabled, fault forced
        ST_FAULT = 2'd1,   // line failed, waiting for a good character
        ST_QUAL  = 2'd2,   // counting consecutive good characters
        ST_LINK  = 2'd3    // line healthy
    } tdm_state_e;

    localparam int unsigned CHAR_BITS_DEF  = 10;
    localparam int unsigned QUIET_CHARS    = 6;
    localparam int unsigned QUIET_BITS_DEF = CHAR_BITS_DEF * QUIET_CHARS;
    localparam int unsigned GOOD_CHARS_DEF = 3;

endpackage

// File: rtl/tdm_run_tracker.sv
module tdm_run_tracker #(
    parameter int unsigned QUIET_LIMIT = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rx_bit,
    output logic edge_o,
    output logic quiet_hit
);
    localparam int unsigned RW = $clog2(QUIET_LIMIT + 1);
    localparam logic [RW-1:0] RUN_MAX  = RW'(QUIET_LIMIT);
    localparam logic [RW-1:0] RUN_TRIP = RW'(QUIET_LIMIT - 1);

    logic          prev_q;
    logic          prev_v;
    logic [RW-1:0] run_q;

    // A bit is a transition only when a valid predecessor exists
    assign edge_o    = en && prev_v && (rx_bit != prev_q);
    assign quiet_hit = en && !edge_o && (run_q >= RUN_TRIP);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            prev_q <= 1'b0;
            prev_v <= 1'b0;
            run_q  <= '0;
        end else begin
            prev_q <= rx_bit;
            prev_v <= 1'b1;
            if (edge_o)
                run_q <= '0;
            else if (run_q != RUN_MAX)
                run_q <= run_q + 1'b1;
        end
    end

    // R9: counter is bounded, never wraps
    p_run_bound_r9: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_MAX);

    // R4: a transition clears the quiet run on the next cycle
    p_run_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (en && edge_o) |=> (run_q == '0));

endmodule

// File: rtl/tdm_char_track.sv
module tdm_char_track (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic edge_i,
    input  logic char_end,
    output logic char_done,
    output logic char_good
);
    logic seen_q;

    // The closing bit's own transition counts for this character
    assign char_done = en && char_end;
    assign char_good = seen_q || edge_i;

    always_ff @(posedge clk) begin
        if (rst || !en)
            seen_q <= 1'b0;
        else if (char_end)
            seen_q <= 1'b0;
        else if (edge_i)
            seen_q <= 1'b1;
    end

    // R7: each character starts with an empty record
    p_char_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (en && char_end) |=> !seen_q);

endmodule

// File: rtl/tdm_fault_fsm.sv
module tdm_fault_fsm
    import tdm_pkg::*;
#(
    parameter int unsigned GOOD_CHARS = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic quiet_hit,
    input  logic char_done,
    input  logic char_good,
    output logic fault_n
);
    localparam int unsigned QW = $clog2(GOOD_CHARS + 1);
    localparam logic [QW-1:0] QUAL_LAST = QW'(GOOD_CHARS - 1);
    localparam tdm_state_e FIRST_GOOD = (GOOD_CHARS == 1) ? ST_LINK : ST_QUAL;

    tdm_state_e    state_q, state_d;
    logic [QW-1:0] qual_q, qual_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        qual_d  = qual_q;
        unique case (state_q)
            ST_OFF: begin
                state_d = ST_FAULT;
                qual_d  = '0;
            end
            ST_FAULT: begin
                if (char_done && char_good) begin
                    state_d = FIRST_GOOD;
                    qual_d  = QW'(1);
                end
            end
            ST_QUAL: begin
                if (quiet_hit) begin
                    state_d = ST_FAULT;
                    qual_d  = '0;
                end else if (char_done) begin
                    if (!char_good) begin
                        state_d = ST_FAULT;
                        qual_d  = '0;
                    end else if (qual_q == QUAL_LAST) begin
                        state_d = ST_LINK;
                        qual_d  = '0;
                    end else begin
                        qual_d  = qual_q + 1'b1;
                    end
                end
            end
            ST_LINK: begin
                if (quiet_hit) begin
                    state_d = ST_FAULT;
                    qual_d  = '0;
                end
            end
            default: begin
                state_d = ST_FAULT;
                qual_d  = '0;
            end
        endcase
        if (!en) begin
            state_d = ST_OFF;
            qual_d  = '0;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FAULT;
            qual_q  <= '0;
        end else begin
            state_q <= state_d;
            qual_q  <= qual_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            ST_LINK: fault_n = 1'b1;
            default: fault_n = 1'b0;
        endcase
    end

    // R8: disable forces the fault on the following cycle
    p_disable_fault_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !fault_n);

    // R3: the flag only drops after a quiet limit or a disable
    p_drop_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(fault_n) |-> ($past(quiet_hit) || !$past(en)));

    // R5: the flag only rises on an enabled good character boundary
    p_rise_cause_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_n) |-> $past(char_done && char_good && en));

    // R6: a bad character during qualification returns to fault
    p_bad_char_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_QUAL && char_done && !char_good) |=> (state_q != ST_LINK));

    // R1: release progress never exceeds the required count
    p_qual_bound_r1: assert property (@(posedge clk) disable iff (rst)
        qual_q < QW'(GOOD_CHARS));

endmodule

// File: rtl/trans_density_mon.sv
module trans_density_mon
    import tdm_pkg::*;
#(
    parameter int unsigned CHAR_BITS  = CHAR_BITS_DEF,
    parameter int unsigned QUIET_BITS = QUIET_BITS_DEF,
    parameter int unsigned GOOD_CHARS = GOOD_CHARS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic rx_bit,
    input  logic char_end,
    output logic link_fault_n
);
    logic bit_edge;
    logic quiet_hit;
    logic char_done;
    logic char_good;

    tdm_run_tracker #(
        .QUIET_LIMIT (QUIET_BITS)
    ) u_run (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .rx_bit    (rx_bit),
        .edge_o    (bit_edge),
        .quiet_hit (quiet_hit)
    );

    tdm_char_track u_char (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .edge_i    (bit_edge),
        .char_end  (char_end),
        .char_done (char_done),
        .char_good (char_good)
    );

    tdm_fault_fsm #(
        .GOOD_CHARS (GOOD_CHARS)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .quiet_hit (quiet_hit),
        .char_done (char_done),
        .char_good (char_good),
        .fault_n   (link_fault_n)
    );

    // R2: a character strobe without a valid character-bit count is meaningless
    initial begin
        a_char_bits_r2: assert (CHAR_BITS > 1 && QUIET_BITS >= CHAR_BITS);
    end

endmodule

// File: tb/trans_density_mon_bench.sv
module trans_density_mon_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1;
    logic rx_bit = 1'b0;
    logic char_end = 1'b0;
    logic link_fault_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [9:0] ALT  = 10'b0101010101;
    localparam logic [9:0] ONES = 10'b1111111111;
    localparam logic [9:0] ZERO = 10'b0000000000;

    // Entry layout: {en, character bits (MSB sent first), expected flag after the character}
    localparam int NV = 26;
    localparam logic [11:0] VEC [NV] = '{
        {1'b1, ALT,           1'b0},  // R2 first bit has no predecessor; qual 1
        {1'b1, ONES,          1'b0},  // R6 quiet character restarts qualification
        {1'b1, ALT,           1'b0},  // qual 1
        {1'b1, ALT,           1'b0},  // qual 2
        {1'b1, ALT,           1'b1},  // R5 released
        {1'b1, ONES,          1'b1},  // quiet 10
        {1'b1, ONES,          1'b1},  // quiet 20
        {1'b1, ONES,          1'b1},  // quiet 30
        {1'b1, ONES,          1'b1},  // quiet 40
        {1'b1, ONES,          1'b1},  // quiet 50
        {1'b1, ONES,          1'b0},  // R3 quiet 60 trips
        {1'b1, ALT,           1'b0},  // qual 1
        {1'b1, 10'b0000000001, 1'b0}, // qual 2
        {1'b1, 10'b1111111110, 1'b1}, // R7 only edge on closing bit
        {1'b1, ZERO,          1'b1},  // quiet 10
        {1'b1, 10'b0000011111, 1'b1}, // R4 mid-character edge resets run
        {1'b1, ONES,          1'b1},
        {1'b1, ONES,          1'b1},
        {1'b1, ONES,          1'b1},
        {1'b1, ONES,          1'b1},
        {1'b1, ONES,          1'b1},  // quiet 54
        {1'b1, ONES,          1'b0},  // R3 trips on 6th bit
        {1'b0, ALT,           1'b0},  // R8 disabled
        {1'b1, ALT,           1'b0},  // R8 re-enabled, qual 1
        {1'b1, ALT,           1'b0},  // qual 2
        {1'b1, ALT,           1'b1}   // released
    };

    trans_density_mon u_trans_density_mon (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .rx_bit       (rx_bit),
        .char_end     (char_end),
        .link_fault_n (link_fault_n)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Inputs change at a falling edge; the next falling edge returns with the result visible
    task automatic send_bit(input logic b, input logic ce, input logic e);
        rx_bit   = b;
        char_end = ce;
        en       = e;
        @(negedge clk);
    endtask

    task automatic send_char(input logic [9:0] c, input logic e);
        for (int i = 9; i >= 0; i--)
            send_bit(c[i], (i == 0), e);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        en = 1'b1;
        rx_bit = 1'b0;
        char_end = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 reset state", link_fault_n, 1'b0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            send_char(VEC[v][10:1], VEC[v][11]);
            check($sformatf("vector %0d (R2..R8)", v), link_fault_n, VEC[v][0]);
        end

        // R3: 59 quiet bits hold, the 60th trips (last bit sent was 1)
        send_bit(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 59; i++) send_bit(1'b0, 1'b0, 1'b1);
        check("R3 59 quiet bits", link_fault_n, 1'b1);
        send_bit(1'b0, 1'b0, 1'b1);
        check("R3 60 quiet bits", link_fault_n, 1'b0);

        // R9: long idle never releases
        for (int c = 0; c < 30; c++) begin
            send_char(ZERO, 1'b1);
            check("R9 long idle", link_fault_n, 1'b0);
        end
        send_char(ALT, 1'b1);
        send_char(ALT, 1'b1);
        check("R9 after idle qual 2", link_fault_n, 1'b0);
        send_char(ALT, 1'b1);
        check("R9 release after idle", link_fault_n, 1'b1);

        // R8: a single disabled bit forces fault at once
        send_bit(1'b0, 1'b0, 1'b0);
        check("R8 one-bit disable", link_fault_n, 1'b0);
        send_char(ALT, 1'b1);
        send_char(ALT, 1'b1);
        check("R8 requalify 2", link_fault_n, 1'b0);
        send_char(ALT, 1'b1);
        check("R8 requalified", link_fault_n, 1'b1);

        // R2: first bit after reset is not a transition
        do_reset();
        send_char(ONES, 1'b1);
        send_char(ALT, 1'b1);
        send_char(ALT, 1'b1);
        check("R2 no edge on first bit", link_fault_n, 1'b0);
        send_char(ALT, 1'b1);
        check("R2 release after restart", link_fault_n, 1'b1);

        // R10: disable on the third qualifying closing bit
        do_reset();
        send_char(ALT, 1'b1);
        send_char(ALT, 1'b1);
        for (int i = 9; i >= 1; i--) send_bit(ALT[i], 1'b0, 1'b1);
        send_bit(ALT[0], 1'b1, 1'b0);
        check("R10 disable beats release", link_fault_n, 1'b0);
        send_char(ALT, 1'b1);
        check("R10 after re-enable", link_fault_n, 1'b0);

        // R1: reset from a healthy link
        send_char(ALT, 1'b1);
        send_char(ALT, 1'b1);
        check("R1 healthy before reset", link_fault_n, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset forces fault", link_fault_n, 1'b0);
        rst = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule